// File: doc/BRIEF.md
# Two-Phase Nonoverlapping Clock Generator

This block turns a fast master clock into the control phases for a double-sampled switched-capacitor front end that feeds two interleaved pipeline channels. A tick counter splits the master clock into sample periods of `TICKS_PER_SAMPLE` ticks. A divide-by-two toggle picks which of two complementary half-rate phases, `phi1` or `phi2`, owns each sample period. Each main phase has an early companion. The early phase rises with its main phase and drops `EARLY_TICKS` ticks before it, which is the order bottom-plate sampling needs.

Every sample period starts with a gap of `NONOVL_TICKS` ticks in which neither main phase is high. Each main phase is also interlocked against the other, so the two can never be high together. A full-rate phase `phi` opens in every sample period at the same tick as the main phases and closes at mid-period. That one signal sets every sampling instant for both channels. A comparator latch enable opens during the hold part of the period, `NONOVL_TICKS` ticks after `phi` closes. All outputs are registered. Each delay is a whole number of master-clock ticks, so the design has no analog delay cells.

Top module: `nov_clockgen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, every output (`phi1`, `phi2`, `phi1e`, `phi2e`, `phi`, `latch_en`) is low after that edge.
- R2: After reset is released, `phi1` is the first main phase to go high. It rises at the second rising edge after release, and `phi2` stays low until then.
- R3: `phi1` and `phi2` are never high in the same cycle. Each main phase rises only after at least one cycle in which the other main phase was low.
- R4: Tick position p counts 0 to T-1 within each sample period, and sample periods alternate, starting with `phi1`. A main phase is high for p from `NONOVL_TICKS` to T-1 of its own sample period, so each main phase has a period of 2T ticks.
- R5: An early phase is high for p from `NONOVL_TICKS` to T-1-`EARLY_TICKS` of its own sample period. It therefore rises in the same cycle as its main phase and falls `EARLY_TICKS` cycles before the main phase falls.
- R6: `phi` is high for p from `NONOVL_TICKS` to T/2-1 in every sample period, so its period is T ticks and it rises together with whichever main phase is starting.
- R7: `latch_en` is high for p from T/2+`NONOVL_TICKS` to T-1 in every sample period. It is therefore high only while `phi` is low and exactly one main phase is high.
- R8: A reset applied in the middle of operation restarts the sequence, and `phi1` is again the first main phase to go high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, `TICKS_PER_SAMPLE` ticks per sample period |
| rst_n | input | 1 | Synchronous active-low reset |
| phi1 | output | 1 | Main half-rate phase of even sample periods |
| phi2 | output | 1 | Main half-rate phase of odd sample periods |
| phi1e | output | 1 | Early version of `phi1` |
| phi2e | output | 1 | Early version of `phi2` |
| phi | output | 1 | Full-rate phase shared by both channels |
| latch_en | output | 1 | Comparator latch enable in the hold part of each period |

## Verification
The assertions rely on `rst_n` being sampled low at the first clock edge, and on `rst_n` changing only away from the rising edge. They also require parameters where `NONOVL_TICKS` and `EARLY_TICKS` are at least 1 and the latch window still fits inside the period. The bench drives `rst_n` only on falling edges and holds it low at start-up. It uses the default timing: 8 ticks per period, with one-tick gap and early offset. It applies a second reset while `phi1` is high, so the restart case is exercised with the outputs active.

// File: rtl/nov_clk_pkg.sv
// Package nov_clk_pkg
// Shared types for the nonoverlapping clock generator.
// Assumes: one main/early pair per half-rate slot.
package nov_clk_pkg;

    // Main phase and its early companion for one half-rate slot
    typedef struct packed {
        logic main;
        logic early;
    } nov_pair_t;

endpackage

// File: rtl/nov_tick_counter.sv
// Module nov_tick_counter
// Counts master-clock ticks inside a sample period. It also toggles a
// divide-by-two flag at the end of every sample period, and that flag
// selects the owning slot.
// Assumes: TICKS_PER_SAMPLE >= 4 and even; synchronous active-low reset.
module nov_tick_counter #(
    parameter int TICKS_PER_SAMPLE = 8,
    parameter int CNT_W            = $clog2(TICKS_PER_SAMPLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] tick,
    output logic             half
);

    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_SAMPLE - 1);

    // Advance the tick; at wrap, toggle the slot selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
            half <= 1'b0;
        end else if (tick == LAST_TICK) begin
            tick <= '0;
            half <= ~half;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // R4
    slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick == '0) && $past(rst_n) |-> (half != $past(half)));

endmodule

// File: rtl/nov_phase_slot.sv
// Module nov_phase_slot
// Produces one main phase and its early phase for the slot selected by
// SLOT. Each output is registered. It is held low while the other slot's
// main phase is high, in the way a cross-coupled gate pair would hold it.
// Assumes: NONOVL_TICKS >= 1, EARLY_TICKS >= 1,
// NONOVL_TICKS + EARLY_TICKS < TICKS_PER_SAMPLE.
module nov_phase_slot
    import nov_clk_pkg::*;
#(
    parameter int TICKS_PER_SAMPLE = 8,
    parameter int NONOVL_TICKS     = 1,
    parameter int EARLY_TICKS      = 1,
    parameter int CNT_W            = $clog2(TICKS_PER_SAMPLE),
    parameter int SLOT             = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tick,
    input  logic             half,
    input  logic             other_main,
    output nov_pair_t        pair
);

    localparam logic [CNT_W-1:0] OPEN_TICK   = CNT_W'(NONOVL_TICKS);
    localparam logic [CNT_W-1:0] EARLY_CLOSE = CNT_W'(TICKS_PER_SAMPLE - 1 - EARLY_TICKS);
    localparam logic             OWN_HALF    = 1'(SLOT);

    logic own_slot;
    logic main_win;
    logic early_win;

    // Window decode for this slot's sample period
    always_comb begin
        own_slot  = (half == OWN_HALF);
        main_win  = own_slot && (tick >= OPEN_TICK);
        early_win = own_slot && (tick >= OPEN_TICK) && (tick <= EARLY_CLOSE);
    end

    // Register the phases, blocked while the other slot is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair <= '0;
        end else begin
            pair.main  <= main_win && !other_main;
            pair.early <= early_win && !other_main;
        end
    end

    // R5
    early_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair.early |-> pair.main);

    // R5
    early_leads_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pair.main) |-> !$past(pair.early));

    // R5
    rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair.main) |-> pair.early);

endmodule

// File: rtl/nov_full_rate.sv
// Module nov_full_rate
// Produces the full-rate sampling phase and the comparator latch enable.
// Both repeat in every sample period, whichever slot owns that period.
// Assumes: NONOVL_TICKS < TICKS_PER_SAMPLE/2, and
// TICKS_PER_SAMPLE/2 + NONOVL_TICKS <= TICKS_PER_SAMPLE - 1.
module nov_full_rate #(
    parameter int TICKS_PER_SAMPLE = 8,
    parameter int NONOVL_TICKS     = 1,
    parameter int CNT_W            = $clog2(TICKS_PER_SAMPLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tick,
    output logic             phi,
    output logic             latch_en
);

    localparam int               HALF_TICKS = TICKS_PER_SAMPLE / 2;
    localparam logic [CNT_W-1:0] OPEN_TICK  = CNT_W'(NONOVL_TICKS);
    localparam logic [CNT_W-1:0] MID_TICK   = CNT_W'(HALF_TICKS);
    localparam logic [CNT_W-1:0] LATCH_OPEN = CNT_W'(HALF_TICKS + NONOVL_TICKS);

    // Register the sampling phase and the latch window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi      <= 1'b0;
            latch_en <= 1'b0;
        end else begin
            phi      <= (tick >= OPEN_TICK) && (tick < MID_TICK);
            latch_en <= (tick >= LATCH_OPEN);
        end
    end

    // R7
    latch_after_phi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_en) |-> !phi && !$past(phi));

endmodule

// File: rtl/nov_clockgen.sv
// Module nov_clockgen
// Top of the nonoverlapping clock generator. A tick counter with a
// divide-by-two slot selector drives two phase slots, one per half-rate
// phase, and a full-rate phase block. Each slot is interlocked against
// the other.
// Assumes: clk runs at TICKS_PER_SAMPLE times the sample rate; rst_n is
// synchronous and active low; the parameter limits of the sub-blocks hold.
module nov_clockgen
    import nov_clk_pkg::*;
#(
    parameter int TICKS_PER_SAMPLE = 8,
    parameter int NONOVL_TICKS     = 1,
    parameter int EARLY_TICKS      = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic phi1,
    output logic phi2,
    output logic phi1e,
    output logic phi2e,
    output logic phi,
    output logic latch_en
);

    localparam int CNT_W   = $clog2(TICKS_PER_SAMPLE);
    localparam int N_SLOTS = 2;

    logic [CNT_W-1:0] tick;
    logic             half;
    nov_pair_t        slot_q [N_SLOTS];

    nov_tick_counter #(
        .TICKS_PER_SAMPLE (TICKS_PER_SAMPLE),
        .CNT_W            (CNT_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .half  (half)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        nov_phase_slot #(
            .TICKS_PER_SAMPLE (TICKS_PER_SAMPLE),
            .NONOVL_TICKS     (NONOVL_TICKS),
            .EARLY_TICKS      (EARLY_TICKS),
            .CNT_W            (CNT_W),
            .SLOT             (g)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .half       (half),
            .other_main (slot_q[N_SLOTS-1-g].main),
            .pair       (slot_q[g])
        );
    end

    nov_full_rate #(
        .TICKS_PER_SAMPLE (TICKS_PER_SAMPLE),
        .NONOVL_TICKS     (NONOVL_TICKS),
        .CNT_W            (CNT_W)
    ) u_full (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .phi      (phi),
        .latch_en (latch_en)
    );

    // Map slot outputs to the phase ports
    always_comb begin
        phi1  = slot_q[0].main;
        phi1e = slot_q[0].early;
        phi2  = slot_q[1].main;
        phi2e = slot_q[1].early;
    end

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi1 && phi2));

    // R3
    gap_before_phi2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi2) |-> !$past(phi1));

    // R3
    gap_before_phi1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi1) |-> !$past(phi2));

    // R6
    phi_with_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phi |-> (phi1 || phi2));

    // R7
    latch_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> (phi1 ^ phi2));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) && $past(rst_n, 2) |-> !(phi1 || phi2 || phi1e || phi2e || phi || latch_en));

endmodule

// File: tb/nov_clockgen_tb.sv
// Bench for nov_clockgen: a driver pushes the expected outputs for every
// cycle into a queue, and a monitor pops and compares them on falling edges.
module nov_clockgen_tb;

    localparam int T   = 8;
    localparam int NOV = 1;
    localparam int ERL = 1;
    localparam int HT  = T / 2;

    logic clk = 1'b0;
    logic rst_n;
    logic phi1, phi2, phi1e, phi2e, phi, latch_en;

    int checks = 0;
    int errors = 0;

    logic [5:0] exp_q [$];

    int cyc = 0;
    int last_p1 = -1, last_p2 = -1, last_ph = -1;
    logic prev_p1 = 1'b0, prev_p2 = 1'b0, prev_ph = 1'b0;
    bit first_seen = 1'b0;
    bit first_is_p1 = 1'b0;
    int period_checks = 0;

    always #5 clk = ~clk;

    nov_clockgen #(
        .TICKS_PER_SAMPLE (T),
        .NONOVL_TICKS     (NOV),
        .EARLY_TICKS      (ERL)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi1     (phi1),
        .phi2     (phi2),
        .phi1e    (phi1e),
        .phi2e    (phi2e),
        .phi      (phi),
        .latch_en (latch_en)
    );

    // Expected {phi1,phi2,phi1e,phi2e,phi,latch_en} for tick index t since release
    function automatic logic [5:0] exp_vec(int t);
        int p = t % T;
        bit odd = ((t / T) % 2) == 1;
        bit m = (p >= NOV);
        bit e = (p >= NOV) && (p <= T - 1 - ERL);
        bit f = (p >= NOV) && (p < HT);
        bit l = (p >= HT + NOV);
        return {m && !odd, m && odd, e && !odd, e && odd, f, l};
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Driver: push one expected vector per rising edge
    task automatic drive_run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            exp_q.push_back(exp_vec(i));
        end
    endtask

    // Monitor: scoreboard compare, overlap, periods, first phase
    always @(negedge clk) begin
        logic [5:0] v;
        cyc++;
        if (exp_q.size() > 0) begin
            v = exp_q.pop_front();
            chk("R4", "phi1", int'(phi1), int'(v[5]));
            chk("R4", "phi2", int'(phi2), int'(v[4]));
            chk("R5", "phi1e", int'(phi1e), int'(v[3]));
            chk("R5", "phi2e", int'(phi2e), int'(v[2]));
            chk("R6", "phi", int'(phi), int'(v[1]));
            chk("R7", "latch_en", int'(latch_en), int'(v[0]));
        end
        if (!rst_n) begin
            first_seen = 1'b0;
            last_p1 = -1; last_p2 = -1; last_ph = -1;
        end else begin
            chk("R3", "phi1&phi2 overlap", int'(phi1 && phi2), 0);
            if (!first_seen && (phi1 || phi2)) begin
                first_seen = 1'b1;
                first_is_p1 = phi1 && !phi2;
            end
            if (phi1 && !prev_p1) begin
                if (last_p1 >= 0) begin chk("R4", "phi1 period", cyc - last_p1, 2 * T); period_checks++; end
                last_p1 = cyc;
            end
            if (phi2 && !prev_p2) begin
                if (last_p2 >= 0) begin chk("R4", "phi2 period", cyc - last_p2, 2 * T); period_checks++; end
                last_p2 = cyc;
            end
            if (phi && !prev_ph) begin
                if (last_ph >= 0) begin chk("R6", "phi period", cyc - last_ph, T); period_checks++; end
                last_ph = cyc;
            end
        end
        prev_p1 = phi1; prev_p2 = phi2; prev_ph = phi;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Main sequence
    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low under reset
        chk("R1", "outputs in reset", int'({phi1, phi2, phi1e, phi2e, phi, latch_en}), 0);
        rst_n = 1'b1;
        drive_run(20 * T);
        @(negedge clk);
        @(negedge clk);
        // R2: phi1 first after release
        chk("R2", "first phase is phi1", int'(first_seen && first_is_p1), 1);
        chk("R4", "period measurements taken", int'(period_checks > 0), 1);

        // R8: mid-run reset while phi1 is high
        while (!phi1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after mid-run reset", int'({phi1, phi2, phi1e, phi2e, phi, latch_en}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_run(12 * T);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "phi1 first after re-reset", int'(first_seen && first_is_p1), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule